// File: doc/BRIEF.md
# Serial Port Register Block

This block is the register front end of a FIFO-equipped serial port. A host reaches it over a simple synchronous bus that carries one access per cycle. The host can read and write a mode register, a control register, a status-flag register and a port-pin register. It writes outgoing bytes to a transmit-data location and takes incoming bytes from a receive-data location. The line side is purely parallel. A transmit byte leaves through a valid/ready pair. Received bytes and break events arrive as one-cycle strobes from a serialiser outside this block.

The status flags are sticky. Hardware events set them. Software clears a flag by writing a 0 to its bit; writing a 1 leaves the flag as it is. Received bytes wait in a 16-entry FIFO, and each read of the receive-data location removes the oldest one. When the control register has transmit enable set, reading the status register makes the transmit-end and transmit-empty flags set again, because the transmitter is taken to finish at once.

Top module: `serport_regs`

## Requirements
- R1: After reset the status register reads 0x60 (transmit-end at bit 6 and transmit-empty at bit 5 set, every other flag clear). Mode, control and port-pin read 0, the receive FIFO is empty and tx_valid is low.
- R2: A write to offset 0x00 (mode) stores the written byte ANDed with 0x7B. A read of 0x00 returns the stored value.
- R3: A write to offset 0x08 (control) stores the written byte ANDed with 0xFB. If bit 5 (transmit enable) of the written byte is 0, the transmit-end flag (bit 6) is set.
- R4: A write to offset 0x0C loads the byte onto tx_data and raises tx_valid. Both are held until a cycle in which tx_ready is high. The write is taken only when tx_valid is low or tx_ready is high in that cycle; otherwise it is ignored.
- R5: The transmit-empty flag (bit 5) clears on the clock edge that completes a tx_valid/tx_ready handshake.
- R6: A write to offset 0x10 (status) clears each of bits 6, 5, 4, 1 and 0 that is written as 0 and keeps each one written as 1. A hardware set of a flag in the same cycle takes priority over the clear.
- R7: A read of offset 0x10 returns the flags as they stood before the read. If control bit 5 is 1 at that time, bits 6 and 5 are set after the read.
- R8: A byte strobed on rx_valid while the FIFO holds fewer than 16 entries is appended. It sets the data-ready flag (bit 0) and, once occupancy reaches the trigger level (default 1), the receive-full flag (bit 1).
- R9: A byte strobed while the FIFO already holds 16 entries is dropped. The FIFO contents do not change.
- R10: A read of offset 0x14 returns the oldest FIFO byte and removes it, or returns 0 if the FIFO is empty. Data-ready clears when the last entry is removed and no byte arrives in the same cycle.
- R11: A pulse on rx_break sets the break flag (bit 4).
- R12: Offset 0x20 is an 8-bit read/write port-pin register. Reads of every other offset, including 0x0C and offsets at or above 0x28, return 0. Writes to them change nothing.
- R13: Read data appears on bus_rdata in the cycle after the read request. After any cycle without a read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Transmitter accepts the pending byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event strobe |

## Verification
Every result is due one clock edge after its stimulus. Read data and the read side effects (FIFO pop, flag re-set) land on the edge that samples the request. Flag sets and clears, FIFO pushes and the transmit load or release all take effect on the edge where their strobe is high. The bench applies each cycle's inputs just after a falling edge and steps its queue-based model by one edge at that moment. At the next falling edge, half a period after the design has updated, it compares bus_rdata, tx_valid and tx_data, so each result is checked in exactly the cycle it is due.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 6;

  // register offsets within the decoded window
  localparam logic [ADDR_W-1:0] OFS_MODE   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_TXDATA = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_RXDATA = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_PINS   = 6'h20;

  // write masks for the mode and control registers
  localparam logic [DATA_W-1:0] MODE_KEEP = 8'h7B;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hFB;
  localparam int unsigned       CTRL_TXEN = 5;

  // status flag bit positions
  localparam int unsigned FL_DRDY  = 0;
  localparam int unsigned FL_RFULL = 1;
  localparam int unsigned FL_BRK   = 4;
  localparam int unsigned FL_TEMPT = 5;
  localparam int unsigned FL_TEND  = 6;

  localparam logic [DATA_W-1:0] FLAG_USED  = 8'h73;
  localparam logic [DATA_W-1:0] FLAG_RESET = 8'h60;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_CTRL,
    SEL_TXDATA,
    SEL_STATUS,
    SEL_RXDATA,
    SEL_PINS
  } reg_sel_e;

endpackage

// File: rtl/serport_rx_fifo.sv
module serport_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic             wr_en, rd_en;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (wr_en) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage carries no reset; only written entries are ever read
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr_q == PW'(i))) mem_q[i] <= data_i;
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> $stable(count_q));

  a_r10_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && (count_q == CW'(1)) && !push_i) |=> empty_o);

endmodule

// File: rtl/serport_tx_stage.sv
module serport_tx_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic             accept_o,
  output logic             free_o
);

  logic             valid_q, valid_d;
  logic [WIDTH-1:0] data_q;
  logic             take;

  assign accept_o = valid_q && ready_i;
  assign free_o   = !valid_q || ready_i;
  assign take     = load_i && free_o;

  always_comb begin
    valid_d = valid_q;
    if (accept_o) valid_d = 1'b0;
    if (take)     valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (take) data_q <= data_i;
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));

endmodule

// File: rtl/serport_flags.sv
module serport_flags #(
  parameter int unsigned      WIDTH    = 8,
  parameter logic [WIDTH-1:0] USED     = 8'h73,
  parameter logic [WIDTH-1:0] RESET_AS = 8'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flags_o
);

  logic [WIDTH-1:0] flags_q, flags_d;

  // a hardware set outranks a clear in the same cycle
  always_comb flags_d = ((flags_q & ~clr_i) | set_i) & USED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= RESET_AS;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & USED) != '0) |=> ((flags_q & $past(set_i & USED)) == $past(set_i & USED)));

  a_r6_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flags_q));

endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int unsigned RX_DEPTH  = 16,
  parameter int unsigned RFULL_LVL = 1,
  localparam int unsigned CW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_break
);

  reg_sel_e          sel;
  logic              wr, rd;
  logic [DATA_W-1:0] mode_q, ctrl_q, pins_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] flags, fl_set, fl_clr;
  logic [DATA_W-1:0] rx_head;
  logic [CW-1:0]     rx_count, rx_after;
  logic              rx_full, rx_empty, push_ok, pop_ok;
  logic              tx_load, tx_accept, tx_free;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  always_comb begin
    case (bus_addr)
      OFS_MODE:   sel = SEL_MODE;
      OFS_CTRL:   sel = SEL_CTRL;
      OFS_TXDATA: sel = SEL_TXDATA;
      OFS_STATUS: sel = SEL_STATUS;
      OFS_RXDATA: sel = SEL_RXDATA;
      OFS_PINS:   sel = SEL_PINS;
      default:    sel = SEL_NONE;
    endcase
  end

  // configuration registers with written-out enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     mode_q <= '0;
    else if (wr && sel == SEL_MODE) mode_q <= bus_wdata & MODE_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ctrl_q <= '0;
    else if (wr && sel == SEL_CTRL) ctrl_q <= bus_wdata & CTRL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pins_q <= '0;
    else if (wr && sel == SEL_PINS) pins_q <= bus_wdata;
  end

  // receive path
  assign push_ok = rx_valid && !rx_full;
  assign pop_ok  = rd && (sel == SEL_RXDATA) && !rx_empty;

  always_comb begin
    rx_after = rx_count;
    if (push_ok) rx_after = rx_after + 1'b1;
    if (pop_ok)  rx_after = rx_after - 1'b1;
  end

  serport_rx_fifo #(
    .DEPTH (RX_DEPTH),
    .WIDTH (DATA_W)
  ) rx_fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (rx_valid),
    .data_i  (rx_data),
    .pop_i   (pop_ok),
    .head_o  (rx_head),
    .count_o (rx_count),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  // transmit path
  assign tx_load = wr && (sel == SEL_TXDATA);

  serport_tx_stage #(
    .WIDTH (DATA_W)
  ) tx_stage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tx_load),
    .data_i   (bus_wdata),
    .ready_i  (tx_ready),
    .valid_o  (tx_valid),
    .data_o   (tx_data),
    .accept_o (tx_accept),
    .free_o   (tx_free)
  );

  // flag events
  always_comb begin
    fl_set = '0;
    fl_clr = '0;
    if (push_ok) begin
      fl_set[FL_DRDY] = 1'b1;
      if (rx_after >= CW'(RFULL_LVL)) fl_set[FL_RFULL] = 1'b1;
    end
    if (pop_ok && (rx_after == '0)) fl_clr[FL_DRDY] = 1'b1;
    if (rx_break)  fl_set[FL_BRK]   = 1'b1;
    if (tx_accept) fl_clr[FL_TEMPT] = 1'b1;
    if (wr && sel == SEL_CTRL && !bus_wdata[CTRL_TXEN]) fl_set[FL_TEND] = 1'b1;
    if (rd && sel == SEL_STATUS && ctrl_q[CTRL_TXEN]) begin
      fl_set[FL_TEND]  = 1'b1;
      fl_set[FL_TEMPT] = 1'b1;
    end
    if (wr && sel == SEL_STATUS) fl_clr = fl_clr | (~bus_wdata & FLAG_USED);
  end

  serport_flags #(
    .WIDTH    (DATA_W),
    .USED     (FLAG_USED),
    .RESET_AS (FLAG_RESET)
  ) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (fl_set),
    .clr_i   (fl_clr),
    .flags_o (flags)
  );

  // read path, registered
  always_comb begin
    rdata_d = '0;
    if (rd) begin
      case (sel)
        SEL_MODE:   rdata_d = mode_q;
        SEL_CTRL:   rdata_d = ctrl_q;
        SEL_STATUS: rdata_d = flags;
        SEL_RXDATA: rdata_d = rx_empty ? '0 : rx_head;
        SEL_PINS:   rdata_d = pins_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  a_r5_tempty_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !(rd && sel == SEL_STATUS && ctrl_q[CTRL_TXEN]))
      |=> !flags[FL_TEMPT]);

  a_r3_txen_low_sets_tend: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CTRL && !bus_wdata[CTRL_TXEN]) |=> flags[FL_TEND]);

  a_r13_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (bus_rdata == '0));

  a_r11_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> flags[FL_BRK]);

endmodule

// File: tb/serport_regs_tb.sv
module serport_regs_tb_top;

  logic       clk;
  logic       rst_n;
  logic       bus_sel, bus_we;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       rx_valid, rx_break;
  logic [7:0] rx_data;

  int n_vec, n_bad;
  bit done;

  serport_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_break  (rx_break)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // behavioural reference state
  logic [7:0] m_mode, m_ctrl, m_pins, m_flags, m_rdata, m_txd;
  logic       m_txv;
  logic [7:0] m_q[$];
  string      m_tag;

  task automatic model_reset();
    m_mode = 0; m_ctrl = 0; m_pins = 0; m_flags = 8'h60;
    m_rdata = 0; m_txd = 0; m_txv = 0; m_q.delete();
    m_tag = "R1";
  endtask

  task automatic compare();
    n_vec++;
    if (bus_rdata !== m_rdata) begin
      n_bad++;
      $display("FAIL %s bus_rdata actual=%02h expected=%02h", m_tag, bus_rdata, m_rdata);
    end
    if (tx_valid !== m_txv) begin
      n_bad++;
      $display("FAIL R4 tx_valid actual=%0b expected=%0b", tx_valid, m_txv);
    end else if (m_txv && tx_data !== m_txd) begin
      n_bad++;
      $display("FAIL R4 tx_data actual=%02h expected=%02h", tx_data, m_txd);
    end
  endtask

  // advance the model across one rising edge using the applied inputs
  task automatic model_step(input logic s, w, input logic [5:0] a, input logic [7:0] d,
                            input logic rv, input logic [7:0] rdv, input logic bk,
                            input logic rdy, input string tg);
    logic [7:0] set, clr, nrd;
    logic acc, fre, push, popped, load;
    set = 0; clr = 0; nrd = 0; popped = 0; load = 0;
    acc  = m_txv && rdy;
    fre  = !m_txv || rdy;
    push = rv && (m_q.size() < 16);
    if (s && !w) begin
      case (a)
        6'h00: nrd = m_mode;
        6'h08: nrd = m_ctrl;
        6'h10: begin nrd = m_flags; if (m_ctrl[5]) set |= 8'h60; end
        6'h14: if (m_q.size() > 0) begin nrd = m_q.pop_front(); popped = 1; end
        6'h20: nrd = m_pins;
        default: nrd = 0;
      endcase
    end
    if (push) m_q.push_back(rdv);
    if (popped && m_q.size() == 0) clr |= 8'h01;
    if (push) set |= 8'h03;          // trigger level 1
    if (bk)   set |= 8'h10;
    if (acc)  clr |= 8'h20;
    if (s && w) begin
      case (a)
        6'h00: m_mode = d & 8'h7B;
        6'h08: begin m_ctrl = d & 8'hFB; if (!d[5]) set |= 8'h40; end
        6'h0C: load = fre;
        6'h10: clr |= ~d & 8'h73;
        6'h20: m_pins = d;
        default: ;
      endcase
    end
    m_flags = ((m_flags & ~clr) | set) & 8'h73;
    if (load) m_txd = d;
    m_txv = load | (m_txv & ~acc);
    m_rdata = nrd;
    if (tg != "") m_tag = tg;
    else if (!(s && !w)) m_tag = "R13";
    else case (a)
      6'h00: m_tag = "R2";
      6'h08: m_tag = "R3";
      6'h10: m_tag = "R5 R6 R7 R8 R11";
      6'h14: m_tag = "R9 R10";
      6'h20: m_tag = "R12";
      default: m_tag = "R12 unmapped";
    endcase
  endtask

  task automatic cyc(input logic s, w, input logic [5:0] a, input logic [7:0] d,
                     input logic rv, input logic [7:0] rdv, input logic bk,
                     input logic rdy, input string tg);
    @(negedge clk);
    compare();
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rdv; rx_break = bk; tx_ready = rdy;
    model_step(s, w, a, d, rv, rdv, bk, rdy, tg);
  endtask

  task automatic rd_reg(input logic [5:0] a, input string tg);
    cyc(1, 0, a, 8'h00, 0, 8'h00, 0, 0, tg);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    cyc(1, 1, a, d, 0, 8'h00, 0, 0, "");
  endtask

  task automatic idle(input logic rdy);
    cyc(0, 0, 6'h00, 8'h00, 0, 8'h00, 0, rdy, "");
  endtask

  initial begin
    done = 0; n_vec = 0; n_bad = 0;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_break = 0; tx_ready = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    rd_reg(6'h10, "R1 status");
    rd_reg(6'h00, "R1 mode");
    rd_reg(6'h14, "R1 fifo empty");
    // R2, R3 masks
    wr_reg(6'h00, 8'hFF); rd_reg(6'h00, "R2 mask");
    wr_reg(6'h08, 8'hFF); rd_reg(6'h08, "R3 mask");
    // R7 status read with transmit enable after clearing both tx flags
    wr_reg(6'h10, 8'h00); rd_reg(6'h10, "R6 cleared"); rd_reg(6'h10, "R7 reset by read");
    // R3 transmit enable off sets transmit-end
    wr_reg(6'h08, 8'h00); wr_reg(6'h10, 8'hBF); wr_reg(6'h08, 8'h00);
    rd_reg(6'h10, "R3 tend");
    // R4, R5 handshake with ready held low, then a blocked write
    wr_reg(6'h0C, 8'hA5); wr_reg(6'h0C, 8'h3C); idle(0); idle(1);
    rd_reg(6'h10, "R5 tempty cleared");
    // R8, R9 fill the FIFO past its depth, R11 break
    for (int i = 0; i < 18; i++) cyc(0, 0, 6'h00, 8'h00, 1, 8'(i + 8'h40), (i == 3), 0, "");
    rd_reg(6'h10, "R8 R11 flags");
    for (int i = 0; i < 17; i++) rd_reg(6'h14, "R9 R10 pop order");
    rd_reg(6'h10, "R10 drdy cleared");
    // R12 port pins and unmapped offsets
    wr_reg(6'h20, 8'h9E); wr_reg(6'h04, 8'hFF); wr_reg(6'h30, 8'hFF);
    rd_reg(6'h20, "R12 pins"); rd_reg(6'h04, "R12 unmapped"); rd_reg(6'h2C, "R12 above window");
    rd_reg(6'h0C, "R12 txdata read");

    // random traffic
    for (int k = 0; k < 6000; k++) begin
      logic [5:0] a;
      logic [7:0] d;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: a = 6'h00; 1: a = 6'h08; 2: a = 6'h0C; 3: a = 6'h10; 4: a = 6'h14;
        5: a = 6'h14; 6: a = 6'h20; 7: a = 6'h04; 8: a = 6'h2C; default: a = 6'h10;
      endcase
      d = 8'($urandom);
      if (a == 6'h10 && $urandom_range(0, 3) != 0) d = d | 8'hEC;
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, a, d,
          (k % 1000 < 300) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0),
          8'($urandom), $urandom_range(0, 15) == 0,
          (k % 700 < 200) ? 1'b0 : ($urandom_range(0, 1) == 1), "");
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule